// File: doc/BRIEF.md
# GPIO Interrupt Controller

This block serves 32 general-purpose pins and turns their input activity into four grouped interrupt lines. Software reaches it through a small register bus: it sets each pin's direction and output value, picks a per-pin input polarity, reads the adjusted input value and enables level or edge interrupt sources per pin. Each line passes through a two-flop synchronizer. It then goes through an optional inverter, and that adjusted value feeds both the readable input register and the edge detector.

A pin raises its interrupt through one of two sources. The level source is the adjusted input value gated by the level enable. The edge source is a sticky captured-edge bit gated by the edge enable. The two are ORed. Only pins configured as inputs may contribute. The per-pin results are reduced in groups of eight onto four interrupt outputs. For interrupts on both edges, software flips the pin's polarity after each event. Writing a polarity bit never counts as an edge in its own right.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset the direction register (offset 0x04) reads all ones, meaning all pins are inputs. Output data, polarity, both enables and all captured edges read zero, `pin_oe` is all zero and `irq_grp` is zero.
- R2: Offset 0x00 holds output data and drives `pin_out`. Offset 0x04 holds the direction bits, where 1 means input, and `pin_oe` is its bitwise inverse. Both registers read back what was written.
- R3: Offset 0x10 is read-only. It returns the line value XOR the polarity register (offset 0x0C, 1 inverts) and reflects a line change after two rising clock edges. Writes to it change nothing.
- R4: A pin's level source is its adjusted input bit AND its level-enable bit (offset 0x1C).
- R5: A 0-to-1 change of a pin's adjusted value sets its captured-edge bit (offset 0x14). With polarity 0 a rising line edge is captured, and with polarity 1 a falling one.
- R6: Captured-edge bits are sticky. A bus write of 0 to a bit clears it, and a write of 1 leaves it as it was.
- R7: When an edge is detected in the same cycle as a write that clears its bit, the bit ends up set.
- R8: A pin's edge source is its captured-edge bit AND its edge-enable bit (offset 0x18). It is ORed with the level source.
- R9: Writing a polarity bit does not by itself capture an edge on that pin.
- R10: A pin whose direction bit is 0 contributes nothing to any interrupt output.
- R11: `irq_grp[g]` is high when any pin 8g..8g+7 has a nonzero combined source.
- R12: Offset 0x08 reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pin_in | input | 32 | Raw line values from the pads |
| pin_out | output | 32 | Output data toward the pads |
| pin_oe | output | 32 | Output enable per pin, high for output pins |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as a read strobe |
| irq_grp | output | 4 | Grouped interrupt outputs, one per eight pins |

## Verification
Edge capture and a bus clear of the captured-edge register can land in the same cycle. The bench provokes this by changing a line exactly two clock edges before the clear write is sampled, so that the synchronized rise meets the write on the third edge. It then reads back the register and expects the colliding bit set and every other bit cleared. A second overlap comes from a polarity write, which changes the adjusted value in the same cycle as the edge detector's history. The bench issues such writes on settled lines and expects no new captured edge.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  localparam int unsigned GPIO_AW = 5;

  localparam logic [GPIO_AW-1:0] OFS_DOUT  = 5'h00;
  localparam logic [GPIO_AW-1:0] OFS_DIR   = 5'h04;
  localparam logic [GPIO_AW-1:0] OFS_HOLE  = 5'h08;
  localparam logic [GPIO_AW-1:0] OFS_POL   = 5'h0C;
  localparam logic [GPIO_AW-1:0] OFS_DIN   = 5'h10;
  localparam logic [GPIO_AW-1:0] OFS_ECAP  = 5'h14;
  localparam logic [GPIO_AW-1:0] OFS_EEN   = 5'h18;
  localparam logic [GPIO_AW-1:0] OFS_LEN   = 5'h1C;

endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stage_q [STAGES];
  logic [WIDTH-1:0] stage_d [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_comb stage_d[s] = d;
      end else begin : g_next
        always_comb stage_d[s] = stage_q[s-1];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= stage_d[s];
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
  import gpio_irq_pkg::*;
#(
  parameter int unsigned N_PINS = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic [GPIO_AW-1:0] bus_addr,
  input  logic [N_PINS-1:0]  bus_wdata,
  output logic [N_PINS-1:0]  bus_rdata,
  input  logic [N_PINS-1:0]  din,
  input  logic [N_PINS-1:0]  ecap_q,
  output logic [N_PINS-1:0]  dout_q,
  output logic [N_PINS-1:0]  dir_q,
  output logic [N_PINS-1:0]  pol_q,
  output logic [N_PINS-1:0]  een_q,
  output logic [N_PINS-1:0]  len_q,
  output logic               pol_we,
  output logic               ecap_we
);

  logic wr_en;
  logic dout_we, dir_we, een_we, len_we;

  always_comb begin
    wr_en   = bus_sel && bus_wr;
    dout_we = wr_en && (bus_addr == OFS_DOUT);
    dir_we  = wr_en && (bus_addr == OFS_DIR);
    pol_we  = wr_en && (bus_addr == OFS_POL);
    ecap_we = wr_en && (bus_addr == OFS_ECAP);
    een_we  = wr_en && (bus_addr == OFS_EEN);
    len_we  = wr_en && (bus_addr == OFS_LEN);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q <= '0;
      dir_q  <= '1;
      pol_q  <= '0;
      een_q  <= '0;
      len_q  <= '0;
    end else begin
      if (dout_we) dout_q <= bus_wdata;
      if (dir_we)  dir_q  <= bus_wdata;
      if (pol_we)  pol_q  <= bus_wdata;
      if (een_we)  een_q  <= bus_wdata;
      if (len_we)  len_q  <= bus_wdata;
    end
  end

  always_comb begin
    unique case (bus_addr)
      OFS_DOUT: bus_rdata = dout_q;
      OFS_DIR:  bus_rdata = dir_q;
      OFS_POL:  bus_rdata = pol_q;
      OFS_DIN:  bus_rdata = din;
      OFS_ECAP: bus_rdata = ecap_q;
      OFS_EEN:  bus_rdata = een_q;
      OFS_LEN:  bus_rdata = len_q;
      default:  bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/gpio_irq_cause.sv
module gpio_irq_cause #(
  parameter int unsigned N_PINS   = 32,
  parameter int unsigned GRP_SIZE = 8,
  localparam int unsigned N_GRP   = N_PINS / GRP_SIZE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_PINS-1:0] sync_in,
  input  logic [N_PINS-1:0] pol_q,
  input  logic              pol_we,
  input  logic              ecap_we,
  input  logic [N_PINS-1:0] wdata,
  input  logic [N_PINS-1:0] dir_q,
  input  logic [N_PINS-1:0] een_q,
  input  logic [N_PINS-1:0] len_q,
  output logic [N_PINS-1:0] adj,
  output logic [N_PINS-1:0] ecap_q,
  output logic [N_GRP-1:0]  irq_grp
);

  logic [N_PINS-1:0] prev_q, prev_d;
  logic [N_PINS-1:0] rise;
  logic [N_PINS-1:0] ecap_d;
  logic [N_PINS-1:0] total;

  always_comb begin
    adj    = sync_in ^ pol_q;
    rise   = adj & ~prev_q;
    // a polarity write reloads history with the value it will produce
    prev_d = pol_we ? (sync_in ^ wdata) : adj;
    ecap_d = (ecap_we ? (ecap_q & wdata) : ecap_q) | rise;
    total  = ((adj & len_q) | (ecap_q & een_q)) & dir_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      ecap_q <= '0;
    end else begin
      prev_q <= prev_d;
      ecap_q <= ecap_d;
    end
  end

  generate
    for (genvar g = 0; g < N_GRP; g++) begin : g_fold
      assign irq_grp[g] = |total[g*GRP_SIZE +: GRP_SIZE];
    end
  endgenerate

endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int unsigned N_PINS   = 32,
  parameter int unsigned GRP_SIZE = 8,
  parameter int unsigned SYNC_LEN = 2,
  localparam int unsigned N_GRP   = N_PINS / GRP_SIZE
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_PINS-1:0]  pin_in,
  output logic [N_PINS-1:0]  pin_out,
  output logic [N_PINS-1:0]  pin_oe,
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic [GPIO_AW-1:0] bus_addr,
  input  logic [N_PINS-1:0]  bus_wdata,
  output logic [N_PINS-1:0]  bus_rdata,
  output logic [N_GRP-1:0]   irq_grp
);

  logic [1:0]        rst_pipe_q;
  logic              rst_sync_n;
  logic [N_PINS-1:0] sync_in, adj, ecap_q;
  logic [N_PINS-1:0] dout_q, dir_q, pol_q, een_q, len_q;
  logic              pol_we, ecap_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  gpio_irq_sync #(.WIDTH(N_PINS), .STAGES(SYNC_LEN)) u_sync (
    .clk(clk), .rst_n(rst_sync_n), .d(pin_in), .q(sync_in)
  );

  gpio_irq_regs #(.N_PINS(N_PINS)) u_regs (
    .clk(clk), .rst_n(rst_sync_n),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .din(adj), .ecap_q(ecap_q),
    .dout_q(dout_q), .dir_q(dir_q), .pol_q(pol_q),
    .een_q(een_q), .len_q(len_q),
    .pol_we(pol_we), .ecap_we(ecap_we)
  );

  gpio_irq_cause #(.N_PINS(N_PINS), .GRP_SIZE(GRP_SIZE)) u_cause (
    .clk(clk), .rst_n(rst_sync_n),
    .sync_in(sync_in), .pol_q(pol_q), .pol_we(pol_we),
    .ecap_we(ecap_we), .wdata(bus_wdata),
    .dir_q(dir_q), .een_q(een_q), .len_q(len_q),
    .adj(adj), .ecap_q(ecap_q), .irq_grp(irq_grp)
  );

  assign pin_out = dout_q;
  assign pin_oe  = ~dir_q;

endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk
  import gpio_irq_pkg::*;
#(
  parameter int unsigned N_PINS = 32,
  parameter int unsigned N_GRP  = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bus_sel,
  input logic               bus_wr,
  input logic [GPIO_AW-1:0] bus_addr,
  input logic [N_PINS-1:0]  bus_wdata,
  input logic [N_PINS-1:0]  bus_rdata,
  input logic [N_PINS-1:0]  adj,
  input logic [N_PINS-1:0]  ecap_q,
  input logic [N_PINS-1:0]  dir_q,
  input logic [N_PINS-1:0]  een_q,
  input logic [N_PINS-1:0]  len_q,
  input logic [N_GRP-1:0]   irq_grp
);

  logic pol_wr_evt, ecap_wr_evt;
  assign pol_wr_evt  = bus_sel && bus_wr && (bus_addr == OFS_POL);
  assign ecap_wr_evt = bus_sel && bus_wr && (bus_addr == OFS_ECAP);

  assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !ecap_wr_evt |=> ((ecap_q & $past(ecap_q)) == $past(ecap_q)));

  assert_rise_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(adj[0]) && !$past(pol_wr_evt)) |=> ecap_q[0]);

  assert_edge_beats_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(adj[0]) && !$past(pol_wr_evt) && ecap_wr_evt && !bus_wdata[0]) |=> ecap_q[0]);

  assert_masked_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ((een_q == '0) && (len_q == '0)) |-> (irq_grp == '0));

  assert_outputs_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_q == '0) |-> (irq_grp == '0));

  assert_hole_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && (bus_addr == OFS_HOLE)) |-> (bus_rdata == '0));

endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(.N_PINS(N_PINS), .N_GRP(N_GRP)) u_chk (
  .clk(clk), .rst_n(rst_sync_n),
  .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .adj(adj), .ecap_q(ecap_q), .dir_q(dir_q),
  .een_q(een_q), .len_q(len_q), .irq_grp(irq_grp)
);

// File: tb/gpio_irq_ctrl_bench.sv
`timescale 1ns/1ps
module gpio_irq_ctrl_bench;

  logic        clk;
  logic        rst_n;
  logic [31:0] pin_in;
  logic [31:0] pin_out, pin_oe;
  logic        bus_sel, bus_wr;
  logic [4:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [3:0]  irq_grp;

  int total_cnt = 0;
  int bad_cnt   = 0;
  bit done      = 0;

  logic [31:0] m_dout, m_dir, m_pol, m_een, m_len, m_ecap, m_line;

  gpio_irq_ctrl u_gpio_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_grp(irq_grp)
  );

  initial clk = 0;
  always #4 clk = ~clk;

  function automatic logic [3:0] exp_irq();
    logic [31:0] tot;
    logic [3:0]  r;
    tot = (((m_line ^ m_pol) & m_len) | (m_ecap & m_een)) & m_dir;
    for (int g = 0; g < 4; g++) r[g] = |tot[g*8 +: 8];
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total_cnt++;
    if (act !== exp) begin
      bad_cnt++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
    case (a)
      5'h00: m_dout = d;
      5'h04: m_dir  = d;
      5'h0C: m_pol  = d;
      5'h14: m_ecap = m_ecap & d;
      5'h18: m_een  = d;
      5'h1C: m_len  = d;
      default: ;
    endcase
  endtask

  task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 0;
  endtask

  task automatic set_lines(input logic [31:0] v);
    m_ecap = m_ecap | ((v ^ m_pol) & ~(m_line ^ m_pol));
    m_line = v;
    @(negedge clk);
    pin_in = v;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    logic [31:0] rd;
    void'($urandom(32'd2024));
    pin_in = 0; bus_sel = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
    m_dout = 0; m_dir = '1; m_pol = 0; m_een = 0; m_len = 0; m_ecap = 0; m_line = 0;
    rst_n = 0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 reset state
    bus_read(5'h04, rd); chk("R1 dir", rd, 32'hFFFF_FFFF);
    bus_read(5'h0C, rd); chk("R1 pol", rd, 0);
    bus_read(5'h14, rd); chk("R1 ecap", rd, 0);
    bus_read(5'h1C, rd); chk("R1 len", rd, 0);
    chk("R1 oe", pin_oe, 0);
    chk("R1 irq", {28'h0, irq_grp}, 0);

    // R12 hole reads zero
    bus_write(5'h08, 32'hDEAD_BEEF);
    bus_read(5'h08, rd); chk("R12 hole", rd, 0);

    // R3 read-only data-in and polarity inversion
    set_lines(32'h0000_00F0);
    bus_write(5'h14, 0);
    bus_write(5'h10, 32'h1234_5678);
    bus_read(5'h10, rd); chk("R3 din", rd, 32'h0000_00F0);
    bus_write(5'h0C, 32'h0000_0FF0);
    bus_read(5'h10, rd); chk("R3 din inverted", rd, 32'h0000_0F00);
    // R9 polarity write captured nothing
    bus_read(5'h14, rd); chk("R9 no edge on pol write", rd, 0);

    // R5 falling edge captured under inverted polarity
    set_lines(32'h0000_00E0);
    bus_read(5'h14, rd); chk("R5 falling capture", rd, 32'h0000_0010);
    // R6 write one keeps, write zero clears
    bus_write(5'h14, 32'hFFFF_FFFF);
    bus_read(5'h14, rd); chk("R6 keep", rd, 32'h0000_0010);
    bus_write(5'h14, 0);
    bus_read(5'h14, rd); chk("R6 clear", rd, 0);

    // R7 edge collides with clear
    bus_write(5'h0C, 0);
    set_lines(0);
    bus_write(5'h14, 0);
    @(negedge clk);
    pin_in = 32'h1;
    @(negedge clk);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = 5'h14; bus_wdata = 0;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
    m_line = 32'h1; m_ecap = 32'h1;
    bus_read(5'h14, rd); chk("R7 edge wins", rd, 32'h1);

    // R8/R11 edge source on group 0, R10 output pin silenced
    bus_write(5'h18, 32'h1);
    chk("R8 edge irq", {28'h0, irq_grp}, 4'b0001);
    bus_write(5'h04, 32'hFFFF_FFFE);
    chk("R10 output pin quiet", {28'h0, irq_grp}, 0);
    bus_write(5'h04, '1);
    // R4 level source in group 3
    bus_write(5'h18, 0);
    bus_write(5'h14, 0);
    bus_write(5'h1C, 32'h8000_0000);
    set_lines(32'h8000_0001);
    chk("R4 level irq", {28'h0, irq_grp}, 4'b1000);
    // R2 output data and direction
    bus_write(5'h00, 32'hA5A5_0F0F);
    bus_write(5'h04, 32'hFFFF_0000);
    chk("R2 pin_out", pin_out, 32'hA5A5_0F0F);
    chk("R2 pin_oe", pin_oe, 32'h0000_FFFF);
    bus_read(5'h00, rd); chk("R2 dout readback", rd, 32'hA5A5_0F0F);

    // random mix
    for (int i = 0; i < 300; i++) begin
      int op;
      op = $urandom_range(0, 9);
      case (op)
        0, 1, 2: set_lines(m_line ^ ($urandom & $urandom & $urandom));
        3: bus_write(5'h04, $urandom | $urandom);
        4: bus_write(5'h0C, $urandom);
        5: bus_write(5'h14, $urandom | $urandom);
        6: bus_write(5'h18, $urandom & $urandom);
        7: bus_write(5'h1C, $urandom & $urandom & $urandom);
        8: bus_write(5'h00, $urandom);
        default: bus_write(5'h10, $urandom);
      endcase
      chk("R11 irq random", {28'h0, irq_grp}, {28'h0, exp_irq()});
      if (i % 5 == 0) begin
        bus_read(5'h10, rd); chk("R3 din random", rd, m_line ^ m_pol);
        bus_read(5'h14, rd); chk("R5 ecap random", rd, m_ecap);
        chk("R2 oe random", pin_oe, ~m_dir);
      end
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total_cnt, bad_cnt);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      total_cnt++;
      bad_cnt++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total_cnt, bad_cnt);
      $finish;
    end
  end

endmodule